// File: doc/BRIEF.md
# Ping-Pong Playback DMA Address Generator

This block produces the memory read addresses for an audio playback stream that alternates between two buffer regions, A and B. Each region has its own base address and byte length. Software sets up both regions and the sample format, then sets the run bit. From then on, every sample request from the audio side that arrives while the block is running produces one fetch strobe. The strobe carries the byte address of the current sample.

The block then moves its offset forward by the byte size of one sample frame. When a region is used up, the offset returns to zero and the other region becomes active. A completion bit is latched for the region that has just finished. Software clears a completion bit by writing a one to it. While it refills the finished region, the other region keeps playing.

The bus master that performs the reads, the converter and the sample clock all sit outside this block. The block only emits an address with a one-cycle strobe.

Top module: `pingpong_dma_addr`

## Requirements
- R1: Bit 0 of the control word (selector 0) is the only bit that enables the engine. While it is 0, sample requests produce no strobe and leave the offset, the active region and the position unchanged. Clearing it pauses playback, and setting it again resumes from the held offset. Control bits 5:1 are stored and read back but have no effect; bits above 5 read as zero.
- R2: All registers are chosen by a 4-bit selector: 0 control, 1 interrupt word, 2 region A base, 3 region B base, 4 region A length, 5 region B length, 6 position, 7 offset, 8 format. Unused selectors read zero. Both bases (32-bit) and both lengths (16-bit) reset to zero and read back what was written.
- R3: The step per accepted request depends on format bits 4 (16-bit samples) and 5 (two channels). It is 1 byte when neither bit is set, 2 bytes when exactly one is set and 4 bytes when both are set.
- R4: A request accepted at a clock edge raises `fetch_stb` for exactly the following cycle. `fetch_addr` then equals the active region's base plus the offset as it was before the step.
- R5: When the offset plus the step is greater than or equal to the active region's length, the offset returns to 0 and the other region becomes active. Finishing region A sets interrupt bit 1, and finishing region B sets interrupt bit 2. A length of 0 wraps on every request.
- R6: Writing the interrupt word clears each of bits 1 and 2 that is written as 1; zero bits leave status unchanged. Writing all ones clears both. A completion in the same cycle as a clear of the same bit leaves the bit set.
- R7: In the interrupt word, all bits other than 1 and 2, including bits 15:5, always read as zero.
- R8: Selector 6 reads the active region's base plus the current offset, and selector 7 reads the current offset. After reset region A is active and the offset is zero.
- R9: The format word resets to 0x0010. Its bits 5:0 are writable, and higher bits read as zero.
- R10: `play_irq` is high exactly while interrupt bit 1 or bit 2 is pending.
- R11: Writes to the position and offset selectors are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register selector for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel`, combinational |
| smp_req | input | 1 | One request per sample frame |
| fetch_stb | output | 1 | One-cycle fetch strobe |
| fetch_addr | output | 32 | Byte address of the fetch |
| play_irq | output | 1 | Summary of pending region completions |

## Verification
If the offset or the active-region bit drifts, the wrong address appears on the very next strobe. The reference model tracks both exactly, so the first bad `fetch_addr` is seen one cycle after the request that caused it. A wrap decided against the wrong length, or one credited to the wrong region, shows up as a wrong interrupt word and a change on `play_irq` in the cycle after the wrapping request. A wrong step size is visible at the next position readback. Read data, strobe, address and interrupt are compared with the model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/pingpong_dma_addr.sv
module pingpong_dma_addr #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              smp_req,
  output logic              fetch_stb,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              play_irq
);

  localparam logic [SEL_W-1:0] S_CTL  = SEL_W'(0);
  localparam logic [SEL_W-1:0] S_IRQ  = SEL_W'(1);
  localparam logic [SEL_W-1:0] S_BASA = SEL_W'(2);
  localparam logic [SEL_W-1:0] S_BASB = SEL_W'(3);
  localparam logic [SEL_W-1:0] S_LENA = SEL_W'(4);
  localparam logic [SEL_W-1:0] S_LENB = SEL_W'(5);
  localparam logic [SEL_W-1:0] S_POS  = SEL_W'(6);
  localparam logic [SEL_W-1:0] S_OFS  = SEL_W'(7);
  localparam logic [SEL_W-1:0] S_FMT  = SEL_W'(8);
  localparam logic [5:0]       FMT_RST = 6'h10;

  logic [5:0]        ctl;
  logic [5:0]        fmt;
  logic [1:0]        done;
  logic [ADDR_W-1:0] base [2];
  logic [LEN_W-1:0]  size [2];
  logic [LEN_W-1:0]  ofs;
  logic              act;

  logic              go;
  logic [1:0]        shift;
  logic [2:0]        step;
  logic [LEN_W:0]    nxt;
  logic              wrap;
  logic [1:0]        fin;
  logic [1:0]        ack;
  logic [ADDR_W-1:0] cur_pos;

  assign go      = smp_req & ctl[0];
  assign shift   = {1'b0, fmt[4]} + {1'b0, fmt[5]};
  assign step    = 3'b001 << shift;
  assign nxt     = {1'b0, ofs} + (LEN_W+1)'(step);
  assign wrap    = nxt >= {1'b0, size[act]};
  assign fin     = (go && wrap) ? (act ? 2'b10 : 2'b01) : 2'b00;
  assign ack     = (reg_wr && reg_sel == S_IRQ) ? reg_wdata[2:1] : 2'b00;
  assign cur_pos = base[act] + ADDR_W'(ofs);
  assign play_irq = |done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl        <= '0;
      fmt        <= FMT_RST;
      done       <= '0;
      base[0]    <= '0;
      base[1]    <= '0;
      size[0]    <= '0;
      size[1]    <= '0;
      ofs        <= '0;
      act        <= 1'b0;
      fetch_stb  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_sel)
          S_CTL:  ctl     <= reg_wdata[5:0];
          S_FMT:  fmt     <= reg_wdata[5:0];
          S_BASA: base[0] <= reg_wdata;
          S_BASB: base[1] <= reg_wdata;
          S_LENA: size[0] <= reg_wdata[LEN_W-1:0];
          S_LENB: size[1] <= reg_wdata[LEN_W-1:0];
          default: ;
        endcase
      end
      done      <= (done & ~ack) | fin;
      fetch_stb <= go;
      if (go) begin
        fetch_addr <= cur_pos;
        if (wrap) begin
          ofs <= '0;
          act <= ~act;
        end else begin
          ofs <= nxt[LEN_W-1:0];
        end
      end
    end
  end

  always_comb begin
    case (reg_sel)
      S_CTL:   reg_rdata = ADDR_W'(ctl);
      S_IRQ:   reg_rdata = ADDR_W'({done, 1'b0});
      S_BASA:  reg_rdata = base[0];
      S_BASB:  reg_rdata = base[1];
      S_LENA:  reg_rdata = ADDR_W'(size[0]);
      S_LENB:  reg_rdata = ADDR_W'(size[1]);
      S_POS:   reg_rdata = cur_pos;
      S_OFS:   reg_rdata = ADDR_W'(ofs);
      S_FMT:   reg_rdata = ADDR_W'(fmt);
      default: reg_rdata = '0;
    endcase
  end

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl[0]) |-> ($stable(ofs) && $stable(act) && !fetch_stb)); // R1

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && act == $past(act)) |->
      ((ofs - $past(ofs)) == LEN_W'(1) || (ofs - $past(ofs)) == LEN_W'(2) ||
       (ofs - $past(ofs)) == LEN_W'(4))); // R3

  AST_SWITCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (act != $past(act)) |-> ($past(act) ? done[1] : done[0])); // R5

  AST_NO_SILENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs == '0 && $past(ofs) != '0) |-> (act != $past(act))); // R5

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(play_irq) |-> (act != $past(act))); // R10

  AST_IRQ_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == S_IRQ) |-> (reg_rdata[ADDR_W-1:3] == '0 && !reg_rdata[0])); // R7

endmodule

// File: tb/sim_pingpong_dma_addr.sv
`timescale 1ns/1ps
module sim_pingpong_dma_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_sel = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        smp_req = 1'b0;
  logic        fetch_stb;
  logic [31:0] fetch_addr;
  logic        play_irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pingpong_dma_addr u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_req(smp_req),
    .fetch_stb(fetch_stb), .fetch_addr(fetch_addr), .play_irq(play_irq));

  // behavioural reference model
  logic [5:0]  m_ctl, m_fmt;
  logic [1:0]  m_irq;
  logic [31:0] m_sa [2];
  int          m_ln [2];
  int          m_ofs;
  int          m_act;
  logic [31:0] m_fa;
  logic        m_fs;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] s);
    case (s)
      4'd0: return {26'd0, m_ctl};
      4'd1: return {29'd0, m_irq, 1'b0};
      4'd2: return m_sa[0];
      4'd3: return m_sa[1];
      4'd4: return m_ln[0];
      4'd5: return m_ln[1];
      4'd6: return m_sa[m_act] + m_ofs;
      4'd7: return m_ofs;
      4'd8: return {26'd0, m_fmt};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [1:0] fin;
    int step;
    fin = 2'b00;
    if (!rst_n) begin
      m_ctl = 0; m_fmt = 6'h10; m_irq = 0; m_sa[0] = 0; m_sa[1] = 0;
      m_ln[0] = 0; m_ln[1] = 0; m_ofs = 0; m_act = 0; m_fa = 0; m_fs = 0;
    end else begin
      if (smp_req && m_ctl[0]) begin
        step = (m_fmt[4] && m_fmt[5]) ? 4 : (m_fmt[4] || m_fmt[5]) ? 2 : 1;
        m_fa = m_sa[m_act] + m_ofs;
        m_fs = 1;
        if (m_ofs + step >= m_ln[m_act]) begin
          fin[m_act] = 1'b1;
          m_ofs = 0;
          m_act = 1 - m_act;
        end else m_ofs = m_ofs + step;
      end else m_fs = 0;
      if (reg_wr) begin
        case (reg_sel)
          4'd0: m_ctl = reg_wdata[5:0];
          4'd1: m_irq = m_irq & ~reg_wdata[2:1];
          4'd2: m_sa[0] = reg_wdata;
          4'd3: m_sa[1] = reg_wdata;
          4'd4: m_ln[0] = reg_wdata[15:0];
          4'd5: m_ln[1] = reg_wdata[15:0];
          4'd8: m_fmt = reg_wdata[5:0];
          default: ;
        endcase
      end
      m_irq = m_irq | fin;
    end
    #2;
    if (rst_n && !finished) begin
      chk("R4 strobe", {31'd0, fetch_stb}, {31'd0, m_fs});
      chk("R4 address", fetch_addr, m_fa);
      chk("R10 summary", {31'd0, play_irq}, {31'd0, |m_irq});
      chk("R2_R8 readback", reg_rdata, m_read(reg_sel));
    end
  end

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_sel = s;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic req();
    @(negedge clk); smp_req = 1;
    @(negedge clk); smp_req = 0;
  endtask

  task automatic req_fetch(input logic [31:0] exp, input string tag);
    req();
    chk({tag, " stb"}, {31'd0, fetch_stb}, 32'd1);
    chk({tag, " addr"}, fetch_addr, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(0, 0, "R1 ctl reset"); rd(1, 0, "R7 irq reset"); rd(2, 0, "R2 baseA reset");
    rd(3, 0, "R2 baseB reset"); rd(4, 0, "R2 lenA reset"); rd(5, 0, "R2 lenB reset");
    rd(8, 32'h10, "R9 fmt reset"); rd(6, 0, "R8 pos reset"); rd(7, 0, "R8 ofs reset");
    rd(12, 0, "R2 unused selector");
    chk("R10 irq reset", {31'd0, play_irq}, 0);

    wr(2, 32'h0000_1000); wr(3, 32'h0000_2000); wr(4, 3); wr(5, 2);
    rd(2, 32'h1000, "R2 baseA write"); rd(5, 2, "R2 lenB write");
    wr(8, 32'hFFFF_FFFF); rd(8, 32'h3F, "R9 fmt mask");
    wr(8, 0);

    // control bits 5:1 without run
    wr(0, 32'hFFFF_FFFE); rd(0, 32'h3E, "R1 ctl readback");
    req(); req();
    chk("R1 no strobe when stopped", {31'd0, fetch_stb}, 0);
    rd(7, 0, "R1 offset held");
    wr(0, 1);

    // mono 8-bit, region A then B
    req_fetch(32'h1000, "R4 A0");
    req_fetch(32'h1001, "R4 A1");
    rd(6, 32'h1002, "R8 position"); rd(7, 2, "R8 offset");
    req_fetch(32'h1002, "R4 A2");
    rd(1, 32'h2, "R5 region A done");
    chk("R10 irq after A", {31'd0, play_irq}, 1);
    rd(6, 32'h2000, "R5 switched to B");
    req_fetch(32'h2000, "R4 B0");
    req_fetch(32'h2001, "R4 B1");
    rd(1, 32'h6, "R5 region B done");

    // acknowledge
    wr(1, 32'h2); rd(1, 32'h4, "R6 ack bit1 only");
    wr(1, 32'h0); rd(1, 32'h4, "R6 zero write no effect");
    wr(1, 32'hFFFF); rd(1, 32'h0, "R6 ack all ones");
    chk("R10 irq cleared", {31'd0, play_irq}, 0);
    wr(1, 32'hFFFF_FFF9); rd(1, 32'h0, "R7 unused irq bits zero");

    // 16-bit mono step 2
    wr(8, 32'h10);
    req_fetch(32'h1000, "R3 16-bit first");
    rd(7, 2, "R3 step 2");
    req_fetch(32'h1002, "R3 16-bit wrap");
    rd(1, 32'h2, "R5 wrap on overshoot");
    // 16-bit stereo step 4
    wr(8, 32'h30);
    req_fetch(32'h2000, "R3 stereo16");
    rd(1, 32'h6, "R5 B done stereo");
    // 8-bit stereo step 2, longer region
    wr(8, 32'h20); wr(4, 8);
    req(); req();
    rd(7, 4, "R3 step 2 stereo8");
    rd(6, 32'h1004, "R8 position stereo8");

    // pause keeps position
    wr(0, 0);
    req(); req();
    chk("R1 paused no strobe", {31'd0, fetch_stb}, 0);
    rd(7, 4, "R1 paused offset");
    wr(0, 1);
    req_fetch(32'h1004, "R1 resume address");

    // read-only registers
    wr(6, 32'hDEAD_BEEF); wr(7, 32'h1);
    rd(7, 6, "R11 offset write ignored");
    rd(6, 32'h1006, "R11 position write ignored");

    // set wins against same-cycle clear
    @(negedge clk); reg_wr = 1; reg_sel = 1; reg_wdata = 32'h6; smp_req = 1;
    @(negedge clk); reg_wr = 0; smp_req = 0;
    rd(1, 32'h2, "R6 set beats clear");

    // zero length wraps each request
    wr(5, 0); wr(1, 32'hFFFF);
    req_fetch(32'h2000, "R5 zero length");
    rd(1, 32'h4, "R5 zero length done");
    rd(6, 32'h1000, "R5 back to A");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule